// File: doc/BRIEF.md
# CCD Pixel Stream Region Tagger

This block sits right after the analog front end of a CCD camera. It receives one digitised sample per valid clock. A line-start strobe and a frame-start strobe frame the stream. For every sample it reports where the sample came from on the sensor: its row and column, the kind of area it lies in, and, inside the effective image, its Bayer colour. Downstream logic uses the region code to pick out light-shielded black pixels for a black-level clamp. The colour code steers the colour pipeline. The block does no arithmetic on pixel values.

Columns are counted from the line-start strobe. The layout along a line is as follows: 24 dummy read-out samples, 2 leading black columns, an image window of 2096 columns, and 54 trailing black columns. The image window is 8 margin columns, then 2080 effective columns, then 8 margin columns. Rows are counted from the frame-start strobe. The layout down the frame is as follows: 2 dummy lines, 5 leading black rows, 1560 image rows, and 2 trailing black rows. The image rows are 8 margin rows, then 1544 effective rows, then 8 margin rows. In monitoring mode the sensor delivers only every seventh line. The row index then steps by seven, so the reported row and the colour phase are those of the true sensor line.

Top module: `ccd_region_tagger`

## Requirements
- R1: Columns are classed by zero-based index: 0..23 dummy, 24..25 leading black, 26..33 margin, 34..2113 effective, 2114..2121 margin, 2122..2175 trailing black, and 2176 or above treated as dummy.
- R2: Rows are classed by zero-based index: 0..1 dummy, 2..6 leading black, 7..14 margin, 15..1558 effective, 1559..1566 margin, 1567..1568 trailing black, and 1569 or above treated as dummy.
- R3: The 3-bit region code is 0 dummy, 1 black column, 2 black row, 3 margin, 4 effective. Priority is dummy (either axis), then black row, then black column, then margin (either axis), then effective.
- R4: In the effective area the 2-bit colour code follows image-relative parity (row-7, col-26). On an even row, an even column is 01 (green beside red) and an odd column is 00 (red). On an odd row, an even column is 11 (blue) and an odd column is 10 (green beside blue).
- R5: The colour code is 00 for every sample outside the effective area.
- R6: The black-average strobe is high only for samples in trailing black columns 2122..2175 on effective rows 15..1558.
- R7: Every output is registered one clock after its input sample. out_valid follows pix_valid with one cycle of delay, and out_data carries the sample. A cycle without a sample gives out_valid low and strobe low on the next cycle.
- R8: The line strobe resets the column to 0. A sample presented in the same cycle as the line strobe is column 0. Each later sample increments the column by one.
- R9: In normal mode (mon_mode=0) the first line strobe after the frame strobe, or in the same cycle as it, sets the row to 0. Each further line strobe adds 1.
- R10: In monitoring mode (mon_mode=1) the first line of a frame is row 4 (sensor line 5 counted from 1). Each further line strobe adds 7. Region and colour are decoded from that true row.
- R11: After reset out_valid, the region, the colour and the strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd | input | 1 | Line-start strobe |
| vd | input | 1 | Frame-start strobe |
| mon_mode | input | 1 | 1 selects the one-line-in-seven monitoring readout, sampled at each line strobe |
| pix_valid | input | 1 | A sample is present this cycle |
| pix_data | input | 12 | Digitised sample |
| out_valid | output | 1 | Tagged sample present |
| out_data | output | 12 | Sample, delayed one clock |
| out_row | output | 11 | Sensor row index of the sample |
| out_col | output | 12 | Column index of the sample |
| out_region | output | 3 | Region code (R3) |
| out_colour | output | 2 | Bayer colour code (R4) |
| out_ob_avg | output | 1 | Black-average strobe for the clamp |

## Verification
The hardest places to reach are the far corners of the frame in monitoring mode. These are the last effective rows and first bottom-margin rows at sensor lines 1551, 1558 and 1565, and the trailing black columns that only appear after more than two thousand samples. The stimulus holds the line strobe high for many consecutive cycles, so each cycle counts as one line start and hundreds of lines pass in as many clocks. It then streams samples to the target column and checks the last tagged output. Directed cases add a line strobe in the middle of a line, a line strobe that coincides with a sample, and coincident frame and line strobes.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;

    typedef enum logic [2:0] {
        RG_DUMMY  = 3'd0,
        RG_OBCOL  = 3'd1,
        RG_OBROW  = 3'd2,
        RG_MARGIN = 3'd3,
        RG_EFF    = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        CF_R  = 2'd0,
        CF_GR = 2'd1,
        CF_GB = 2'd2,
        CF_B  = 2'd3
    } cfa_e;

    typedef enum logic [2:0] {
        AX_DUMMY    = 3'd0,
        AX_OB_LEAD  = 3'd1,
        AX_MARGIN   = 3'd2,
        AX_ACTIVE   = 3'd3,
        AX_OB_TRAIL = 3'd4,
        AX_BEYOND   = 3'd5
    } axis_e;

endpackage

// File: rtl/ccd_axis_decode.sv
module ccd_axis_decode
    import ccd_tag_pkg::*;
#(
    parameter int POS_W    = 12,
    parameter int N_DUMMY  = 24,
    parameter int N_OB_LD  = 2,
    parameter int N_IMG    = 2096,
    parameter int N_EFF    = 2080,
    parameter int N_OB_TR  = 54
) (
    input  logic [POS_W-1:0] pos,
    output axis_e            cls,
    output logic             img_odd
);
    localparam int MARG_LD   = (N_IMG - N_EFF) / 2;
    localparam int IMG_START = N_DUMMY + N_OB_LD;
    localparam int EFF_START = IMG_START + MARG_LD;
    localparam int EFF_END   = EFF_START + N_EFF;
    localparam int IMG_END   = IMG_START + N_IMG;
    localparam int AX_END    = IMG_END + N_OB_TR;
    localparam logic START_ODD = 1'((IMG_START % 2) != 0);

    logic [31:0] p32;

    always_comb begin
        p32 = {{(32-POS_W){1'b0}}, pos};
        if (p32 < 32'(N_DUMMY))        cls = AX_DUMMY;
        else if (p32 < 32'(IMG_START)) cls = AX_OB_LEAD;
        else if (p32 < 32'(EFF_START)) cls = AX_MARGIN;
        else if (p32 < 32'(EFF_END))   cls = AX_ACTIVE;
        else if (p32 < 32'(IMG_END))   cls = AX_MARGIN;
        else if (p32 < 32'(AX_END))    cls = AX_OB_TRAIL;
        else                           cls = AX_BEYOND;
        img_odd = pos[0] ^ START_ODD;
    end

endmodule

// File: rtl/ccd_region_merge.sv
module ccd_region_merge
    import ccd_tag_pkg::*;
(
    input  axis_e   h_cls,
    input  axis_e   v_cls,
    input  logic    h_odd,
    input  logic    v_odd,
    output region_e region,
    output cfa_e    colour,
    output logic    ob_avg
);
    logic h_dum, v_dum, h_ob, v_ob, any_marg;

    always_comb begin
        h_dum    = (h_cls == AX_DUMMY) || (h_cls == AX_BEYOND);
        v_dum    = (v_cls == AX_DUMMY) || (v_cls == AX_BEYOND);
        h_ob     = (h_cls == AX_OB_LEAD) || (h_cls == AX_OB_TRAIL);
        v_ob     = (v_cls == AX_OB_LEAD) || (v_cls == AX_OB_TRAIL);
        any_marg = (h_cls == AX_MARGIN) || (v_cls == AX_MARGIN);

        if (h_dum || v_dum) region = RG_DUMMY;
        else if (v_ob)      region = RG_OBROW;
        else if (h_ob)      region = RG_OBCOL;
        else if (any_marg)  region = RG_MARGIN;
        else                region = RG_EFF;

        colour = CF_R;
        if (region == RG_EFF) begin
            case ({v_odd, h_odd})
                2'b00:   colour = CF_GR;
                2'b01:   colour = CF_R;
                2'b10:   colour = CF_B;
                default: colour = CF_GB;
            endcase
        end

        ob_avg = (v_cls == AX_ACTIVE) && (h_cls == AX_OB_TRAIL);
    end

endmodule

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
    import ccd_tag_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int H_DUMMY   = 24,
    parameter int H_OB_LD   = 2,
    parameter int H_IMG     = 2096,
    parameter int H_EFF     = 2080,
    parameter int H_OB_TR   = 54,
    parameter int V_DUMMY   = 2,
    parameter int V_OB_LD   = 5,
    parameter int V_IMG     = 1560,
    parameter int V_EFF     = 1544,
    parameter int V_OB_TR   = 2,
    parameter int MON_STEP  = 7,
    parameter int MON_FIRST = 4,
    localparam int H_TOTAL  = H_DUMMY + H_OB_LD + H_IMG + H_OB_TR,
    localparam int V_TOTAL  = V_DUMMY + V_OB_LD + V_IMG + V_OB_TR,
    localparam int COL_W    = $clog2(H_TOTAL + 1),
    localparam int ROW_W    = $clog2(V_TOTAL + MON_STEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hd,
    input  logic              vd,
    input  logic              mon_mode,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col,
    output logic [2:0]        out_region,
    output logic [1:0]        out_colour,
    output logic              out_ob_avg
);
    localparam logic [COL_W-1:0] COL_MAX = '1;
    localparam logic [ROW_W-1:0] ROW_MAX = '1;

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic              pend;
        logic              o_valid;
        logic [DATA_W-1:0] o_data;
        logic [ROW_W-1:0]  o_row;
        logic [COL_W-1:0]  o_col;
        region_e           o_region;
        cfa_e              o_colour;
        logic              o_ob;
    } st_t;

    st_t st_d, st_q;

    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;
    logic [31:0]      step;
    logic [31:0]      row_sum;

    // position of the sample in this cycle, including a line start now
    always_comb begin
        step    = mon_mode ? 32'(MON_STEP) : 32'd1;
        row_sum = {{(32-ROW_W){1'b0}}, st_q.row} + step;
        cur_col = hd ? '0 : st_q.col;
        cur_row = st_q.row;
        if (hd) begin
            if (vd || st_q.pend)
                cur_row = mon_mode ? ROW_W'(MON_FIRST) : '0;
            else if (row_sum > {{(32-ROW_W){1'b0}}, ROW_MAX})
                cur_row = ROW_MAX;
            else
                cur_row = ROW_W'(row_sum);
        end
    end

    axis_e h_cls, v_cls;
    logic  h_odd, v_odd;
    region_e m_region;
    cfa_e    m_colour;
    logic    m_ob;

    ccd_axis_decode #(
        .POS_W(COL_W), .N_DUMMY(H_DUMMY), .N_OB_LD(H_OB_LD),
        .N_IMG(H_IMG), .N_EFF(H_EFF), .N_OB_TR(H_OB_TR)
    ) i_hdec (
        .pos(cur_col), .cls(h_cls), .img_odd(h_odd)
    );

    ccd_axis_decode #(
        .POS_W(ROW_W), .N_DUMMY(V_DUMMY), .N_OB_LD(V_OB_LD),
        .N_IMG(V_IMG), .N_EFF(V_EFF), .N_OB_TR(V_OB_TR)
    ) i_vdec (
        .pos(cur_row), .cls(v_cls), .img_odd(v_odd)
    );

    ccd_region_merge i_merge (
        .h_cls(h_cls), .v_cls(v_cls), .h_odd(h_odd), .v_odd(v_odd),
        .region(m_region), .colour(m_colour), .ob_avg(m_ob)
    );

    always_comb begin
        st_d      = st_q;
        st_d.row  = cur_row;
        st_d.pend = hd ? 1'b0 : (vd ? 1'b1 : st_q.pend);
        if (pix_valid && cur_col != COL_MAX)
            st_d.col = cur_col + COL_W'(1);
        else
            st_d.col = cur_col;

        st_d.o_valid = pix_valid;
        if (pix_valid) begin
            st_d.o_data   = pix_data;
            st_d.o_row    = cur_row;
            st_d.o_col    = cur_col;
            st_d.o_region = m_region;
            st_d.o_colour = m_colour;
            st_d.o_ob     = m_ob;
        end else begin
            st_d.o_region = RG_DUMMY;
            st_d.o_colour = CF_R;
            st_d.o_ob     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.pend     <= 1'b1;
            st_q.o_region <= RG_DUMMY;
            st_q.o_colour <= CF_R;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.o_valid;
    assign out_data   = st_q.o_data;
    assign out_row    = st_q.o_row;
    assign out_col    = st_q.o_col;
    assign out_region = st_q.o_region;
    assign out_colour = st_q.o_colour;
    assign out_ob_avg = st_q.o_ob;

    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(pix_valid)));

    // R8
    line_col_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && hd) |=> (out_col == '0));

    // R8
    col_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pix_valid && !hd && out_col != COL_MAX)
        |=> (out_col == $past(out_col) + COL_W'(1)));

    // R5
    colour_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_colour != 2'd0) |-> (out_valid && out_region == 3'd4));

    // R6
    ob_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_ob_avg |-> (out_valid && out_region == 3'd1));

    // R9
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hd && !vd && !st_q.pend && !mon_mode && st_q.row != ROW_MAX)
        |=> (st_q.row == $past(st_q.row) + ROW_W'(1)));

    // R10
    mon_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hd && !vd && !st_q.pend && mon_mode
         && st_q.row < ROW_MAX - ROW_W'(MON_STEP))
        |=> (st_q.row == $past(st_q.row) + ROW_W'(MON_STEP)));

endmodule

// File: tb/test_ccd_region_tagger.sv
module test_ccd_region_tagger;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hd = 1'b0, vd = 1'b0, mon_mode = 1'b0, pix_valid = 1'b0;
    logic [11:0] pix_data = '0;
    logic        out_valid;
    logic [11:0] out_data;
    logic [10:0] out_row;
    logic [11:0] out_col;
    logic [2:0]  out_region;
    logic [1:0]  out_colour;
    logic        out_ob_avg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ccd_region_tagger i_ccd_region_tagger (
        .clk(clk), .rst_n(rst_n), .hd(hd), .vd(vd), .mon_mode(mon_mode),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .out_valid(out_valid), .out_data(out_data), .out_row(out_row),
        .out_col(out_col), .out_region(out_region), .out_colour(out_colour),
        .out_ob_avg(out_ob_avg)
    );

    typedef struct packed {
        bit mon; int nl; int col; int row; int rg; int cf; bit ob;
    } vec_t;

    // mon, line strobes, column, then expected row, region, colour, strobe
    localparam vec_t VECS [24] = '{
        '{1'b0,    1,    5,    0, 0, 0, 1'b0},  // R2 R3 dummy row
        '{1'b0,    3,  100,    2, 2, 0, 1'b0},  // R2 black row
        '{1'b0,   16,   34,   15, 4, 1, 1'b0},  // R4 even row even col
        '{1'b0,   16,   35,   15, 4, 0, 1'b0},  // R4 even row odd col
        '{1'b0,   17,   34,   16, 4, 3, 1'b0},  // R4 odd row even col
        '{1'b0,   17, 2113,   16, 4, 2, 1'b0},  // R1 R4 last effective col
        '{1'b0,   17, 2114,   16, 3, 0, 1'b0},  // R1 R5 right margin
        '{1'b0,   17, 2122,   16, 1, 0, 1'b1},  // R6 first trailing black
        '{1'b0,   17, 2175,   16, 1, 0, 1'b1},  // R6 last trailing black
        '{1'b0,   17, 2176,   16, 0, 0, 1'b0},  // R1 beyond line
        '{1'b0,   17,   24,   16, 1, 0, 1'b0},  // R1 R6 leading black
        '{1'b0,   17,   23,   16, 0, 0, 1'b0},  // R1 last dummy
        '{1'b0,   10, 2130,    9, 1, 0, 1'b0},  // R3 R6 black col on margin row
        '{1'b0, 1560,  500, 1559, 3, 0, 1'b0},  // R2 bottom margin
        '{1'b0, 1568,   40, 1567, 2, 0, 1'b0},  // R2 trailing black row
        '{1'b0,   15,   40,   14, 3, 0, 1'b0},  // R2 last top margin
        '{1'b1,    1,   34,    4, 2, 0, 1'b0},  // R10 first monitor line
        '{1'b1,    2,   34,   11, 3, 0, 1'b0},  // R10 second monitor line
        '{1'b1,    3,   34,   18, 4, 3, 1'b0},  // R10 colour from true row
        '{1'b1,    4,   35,   25, 4, 0, 1'b0},  // R10 red
        '{1'b1,    4, 2122,   25, 1, 0, 1'b1},  // R10 R6 strobe
        '{1'b1,  222,   34, 1551, 4, 1, 1'b0},  // R10 deep frame
        '{1'b1,  223,   34, 1558, 4, 3, 1'b0},  // R10 last effective row
        '{1'b1,  224,   34, 1565, 3, 0, 1'b0}   // R10 bottom margin
    };

    task automatic check_eq(input string req, input string what,
                            input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report_and_end();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string tag;
        tag = $sformatf("vec%0d", idx);
        @(negedge clk);
        vd = 1'b1; hd = 1'b0; pix_valid = 1'b0; mon_mode = v.mon;
        @(negedge clk);
        vd = 1'b0; hd = 1'b1;
        for (int i = 1; i < v.nl; i++) @(negedge clk);
        @(negedge clk);
        hd = 1'b0;
        for (int c = 0; c <= v.col; c++) begin
            pix_valid = 1'b1;
            pix_data  = 12'(c * 3 + 1);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        check_eq({tag, " R7"},  "valid",  int'(out_valid), 1);
        check_eq({tag, " R7"},  "data",   int'(out_data), (v.col * 3 + 1) % 4096);
        check_eq({tag, " R8"},  "col",    int'(out_col), v.col);
        check_eq({tag, " R9"},  "row",    int'(out_row), v.row);
        check_eq({tag, " R3"},  "region", int'(out_region), v.rg);
        check_eq({tag, " R4"},  "colour", int'(out_colour), v.cf);
        check_eq({tag, " R6"},  "strobe", int'(out_ob_avg), int'(v.ob));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_and_end();
    end

    initial begin
        pix_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state, even with a sample presented during reset
        check_eq("R11", "valid",  int'(out_valid), 0);
        check_eq("R11", "region", int'(out_region), 0);
        check_eq("R11", "colour", int'(out_colour), 0);
        check_eq("R11", "strobe", int'(out_ob_avg), 0);
        pix_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 24; k++) run_vec(VECS[k], k);

        // R8 line strobe in mid-line together with a sample, normal mode
        @(negedge clk);
        mon_mode = 1'b0; vd = 1'b1;
        @(negedge clk);
        vd = 1'b0; hd = 1'b1;
        @(negedge clk);
        hd = 1'b0;
        for (int c = 0; c < 5; c++) begin
            pix_valid = 1'b1;
            @(negedge clk);
        end
        check_eq("R8", "col before strobe", int'(out_col), 4);
        hd = 1'b1; pix_valid = 1'b1;
        @(negedge clk);
        hd = 1'b0; pix_valid = 1'b0;
        check_eq("R8", "col with strobe", int'(out_col), 0);
        check_eq("R9", "row second line", int'(out_row), 1);
        @(negedge clk);
        // R7 no sample in the previous cycle
        check_eq("R7", "idle valid",  int'(out_valid), 0);
        check_eq("R7", "idle strobe", int'(out_ob_avg), 0);

        // R9 frame and line strobes in the same cycle
        vd = 1'b1; hd = 1'b1;
        @(negedge clk);
        vd = 1'b0; hd = 1'b0; pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        check_eq("R9", "row after joint strobe", int'(out_row), 0);
        check_eq("R8", "col after joint strobe", int'(out_col), 0);

        // R10 monitor mode, frame and line strobe together with a sample
        mon_mode = 1'b1; vd = 1'b1; hd = 1'b1; pix_valid = 1'b1;
        @(negedge clk);
        vd = 1'b0; hd = 1'b0; pix_valid = 1'b0;
        check_eq("R10", "row joint monitor", int'(out_row), 4);
        check_eq("R3",  "region joint monitor", int'(out_region), 0);

        report_and_end();
    end

endmodule